// File: doc/BRIEF.md
# Superpage-Aware Translation Entry Matcher

This block holds one entry of a translation lookaside buffer for a four-level virtual address scheme. The entry stores a 36-bit virtual page number tag, a valid bit and three page-size flags: 512 GiB, 1 GiB and 2 MiB. When no flag is set, the entry maps a 4 KiB page. A lookup presents the virtual page number as four 9-bit level indices. The entry answers in the same cycle with a hit flag and a one-hot report of the size of the page that hit.

The stored page size sets how many levels take part in the compare. A 512 GiB entry compares only the top level. A 1 GiB entry compares the top two levels, a 2 MiB entry the top three, and a 4 KiB entry all four. The levels that a superpage covers are ignored.

The entry is rewritten only when its replace enable is high. A larger translation buffer places many of these entries side by side and drives their replace enables from its own replacement logic.

Top module: `tlbm_entry_match`

## Requirements
- R1: After reset the entry is invalid with all size flags clear. Every lookup, including an all-zero one, gives hit_o=0 and all three size outputs low.
- R2: The stored valid bit, size flags and tag change only on a rising clock edge where upd_en_i=1. With upd_en_i=0, a stored entry keeps hitting whatever the update inputs carry.
- R3: With no size flag stored (4 KiB page), a hit needs all four levels equal. Tag bits 8:0 are level 0, 17:9 are level 1, 26:18 are level 2 and 35:27 are level 3.
- R4: With the 2 MiB flag stored, a hit needs levels 3, 2 and 1 equal. Level 0 is ignored.
- R5: With the 1 GiB flag stored, a hit needs levels 3 and 2 equal. Levels 1 and 0 are ignored.
- R6: With the 512 GiB flag stored, a hit needs only level 3 equal. Levels 2, 1 and 0 are ignored.
- R7: A lookup that differs from the stored tag at any compared level gives hit_o=0.
- R8: An entry written with upd_valid_i=0 never hits, even when the lookup equals the stored tag exactly.
- R9: On a hit, exactly the size output that matches the stored page size is high (none for 4 KiB). On a miss, all size outputs are low.
- R10: If more than one size flag is written, the largest page size wins, both for the levels compared and for the size output.
- R11: Lookup outputs are combinational from the stored state and the current lookup inputs. A lookup in the same cycle as a write sees the old entry, and the new entry is visible after that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_en_i | input | 1 | Replace enable; the entry is written on this clock edge |
| upd_valid_i | input | 1 | Valid bit to store |
| upd_sz512g_i | input | 1 | Store as a 512 GiB page |
| upd_sz1g_i | input | 1 | Store as a 1 GiB page |
| upd_sz2m_i | input | 1 | Store as a 2 MiB page |
| upd_vpn_i | input | 36 | Virtual page number tag to store |
| lk_idx0_i | input | 9 | Lookup level 0 index |
| lk_idx1_i | input | 9 | Lookup level 1 index |
| lk_idx2_i | input | 9 | Lookup level 2 index |
| lk_idx3_i | input | 9 | Lookup level 3 index |
| hit_o | output | 1 | Lookup matches the valid stored entry |
| hit_512g_o | output | 1 | Hit on a 512 GiB entry |
| hit_1g_o | output | 1 | Hit on a 1 GiB entry |
| hit_2m_o | output | 1 | Hit on a 2 MiB entry |

## Verification
A write takes effect at the rising edge on which upd_en_i is high, so each stimulus drives the update inputs at a falling edge. The check follows one rising edge later. The lookup results have no register between the inputs and the outputs. The bench therefore drives the lookup indices at a falling edge and samples hit_o and the size outputs 1 ns later, well clear of the next rising edge. The same-cycle case drives a write and a lookup together and samples before the edge to see the old entry. It then samples again after the edge to see the new one.

// File: rtl/tlbm_pkg.sv
`timescale 1ns/1ps
package tlbm_pkg;
  // number of translation levels in the virtual address
  localparam int LVLS  = 4;
  localparam int LVL_W = $clog2(LVLS);

  // resolved page size; the code equals the lowest level that is compared
  typedef enum logic [LVL_W-1:0] {
    PG_4K   = 2'd0,
    PG_2M   = 2'd1,
    PG_1G   = 2'd2,
    PG_512G = 2'd3
  } pg_size_e;

  // raw size flags as stored, largest first
  typedef struct packed {
    logic sz512g;
    logic sz1g;
    logic sz2m;
  } size_flags_t;
endpackage

// File: rtl/tlbm_store.sv
`timescale 1ns/1ps
module tlbm_store
  import tlbm_pkg::*;
#(
  parameter int IDX_W = 9,
  localparam int TAG_W = LVLS * IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic             wr_valid_i,
  input  size_flags_t      wr_flags_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  output logic             valid_o,
  output size_flags_t      flags_o,
  output logic [TAG_W-1:0] tag_o
);
  logic             valid_q;
  size_flags_t      flags_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      flags_q <= '0;
      tag_q   <= '0;
    end else if (wr_en_i) begin
      valid_q <= wr_valid_i;
      flags_q <= wr_flags_i;
      tag_q   <= wr_tag_i;
    end
  end

  assign valid_o = valid_q;
  assign flags_o = flags_q;
  assign tag_o   = tag_q;

  // R2: a write captures the update bundle
  assert_wr_capture_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> (valid_q == $past(wr_valid_i)) && (tag_q == $past(wr_tag_i)));

  // R2: no write, no change
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable(valid_q) && $stable(flags_q) && $stable(tag_q));
endmodule

// File: rtl/tlbm_size_sel.sv
`timescale 1ns/1ps
module tlbm_size_sel
  import tlbm_pkg::*;
(
  input  size_flags_t     flags_i,
  output pg_size_e        size_o,
  output logic [LVLS-1:0] mask_o
);
  // largest page size wins when several flags are set (R10)
  always_comb begin
    if (flags_i.sz512g)    size_o = PG_512G;
    else if (flags_i.sz1g) size_o = PG_1G;
    else if (flags_i.sz2m) size_o = PG_2M;
    else                   size_o = PG_4K;
  end

  // a level takes part in the compare when it is at or above the size code
  for (genvar l = 0; l < LVLS; l++) begin : g_mask
    assign mask_o[l] = (LVL_W'(l) >= size_o);
  end
endmodule

// File: rtl/tlbm_level_cmp.sv
`timescale 1ns/1ps
module tlbm_level_cmp
  import tlbm_pkg::*;
#(
  parameter int IDX_W = 9,
  localparam int TAG_W = LVLS * IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0] look_i,
  input  logic [LVLS-1:0]  mask_i,
  output logic             hit_o
);
  logic [LVLS-1:0] lvl_eq;

  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    assign lvl_eq[l] = (tag_i[l*IDX_W +: IDX_W] == look_i[l*IDX_W +: IDX_W]);
  end

  assign hit_o = valid_i && (&(lvl_eq | ~mask_i));

  // R7: the top level is always compared, so a hit implies it matched
  assert_top_level_R7: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (tag_i[TAG_W-1 -: IDX_W] == look_i[TAG_W-1 -: IDX_W]));
endmodule

// File: rtl/tlbm_entry_match.sv
`timescale 1ns/1ps
module tlbm_entry_match
  import tlbm_pkg::*;
#(
  parameter int IDX_W = 9,
  localparam int TAG_W = LVLS * IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_en_i,
  input  logic             upd_valid_i,
  input  logic             upd_sz512g_i,
  input  logic             upd_sz1g_i,
  input  logic             upd_sz2m_i,
  input  logic [TAG_W-1:0] upd_vpn_i,
  input  logic [IDX_W-1:0] lk_idx0_i,
  input  logic [IDX_W-1:0] lk_idx1_i,
  input  logic [IDX_W-1:0] lk_idx2_i,
  input  logic [IDX_W-1:0] lk_idx3_i,
  output logic             hit_o,
  output logic             hit_512g_o,
  output logic             hit_1g_o,
  output logic             hit_2m_o
);
  size_flags_t      wr_flags;
  logic             st_valid;
  size_flags_t      st_flags;
  logic [TAG_W-1:0] st_tag;
  logic [TAG_W-1:0] look_vpn;
  pg_size_e         st_size;
  logic [LVLS-1:0]  cmp_mask;
  logic             hit;

  assign wr_flags = '{sz512g: upd_sz512g_i, sz1g: upd_sz1g_i, sz2m: upd_sz2m_i};
  assign look_vpn = {lk_idx3_i, lk_idx2_i, lk_idx1_i, lk_idx0_i};

  tlbm_store #(.IDX_W(IDX_W)) store_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (upd_en_i),
    .wr_valid_i (upd_valid_i),
    .wr_flags_i (wr_flags),
    .wr_tag_i   (upd_vpn_i),
    .valid_o    (st_valid),
    .flags_o    (st_flags),
    .tag_o      (st_tag)
  );

  tlbm_size_sel size_i (
    .flags_i (st_flags),
    .size_o  (st_size),
    .mask_o  (cmp_mask)
  );

  tlbm_level_cmp #(.IDX_W(IDX_W)) cmp_i (
    .clk     (clk),
    .rst     (rst),
    .valid_i (st_valid),
    .tag_i   (st_tag),
    .look_i  (look_vpn),
    .mask_i  (cmp_mask),
    .hit_o   (hit)
  );

  assign hit_o      = hit;
  assign hit_512g_o = hit && (st_size == PG_512G);
  assign hit_1g_o   = hit && (st_size == PG_1G);
  assign hit_2m_o   = hit && (st_size == PG_2M);

  // R9: at most one size output, and only together with a hit
  assert_size_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit_512g_o, hit_1g_o, hit_2m_o}));
  assert_size_needs_hit_R9: assert property (@(posedge clk) disable iff (rst)
    (hit_512g_o || hit_1g_o || hit_2m_o) |-> hit_o);

  // R8: an entry written invalid cannot hit on the following cycle
  assert_invalid_no_hit_R8: assert property (@(posedge clk) disable iff (rst)
    (upd_en_i && !upd_valid_i) |=> !hit_o);
endmodule

// File: tb/tlbm_entry_match_tb.sv
`timescale 1ns/1ps
module tlbm_entry_match_tb_top;
  localparam int IDX_W = 9;
  localparam int TAG_W = 4 * IDX_W;
  localparam int NVEC  = 12;
  localparam int VW    = 4 + 1 + 3 + TAG_W + TAG_W + 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             upd_en = 1'b0, upd_valid = 1'b0;
  logic             s512 = 1'b0, s1g = 1'b0, s2m = 1'b0;
  logic [TAG_W-1:0] upd_vpn = '0;
  logic [IDX_W-1:0] l0 = '0, l1 = '0, l2 = '0, l3 = '0;
  logic             hit, h512, h1g, h2m;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  tlbm_entry_match #(.IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst(rst),
    .upd_en_i(upd_en), .upd_valid_i(upd_valid),
    .upd_sz512g_i(s512), .upd_sz1g_i(s1g), .upd_sz2m_i(s2m),
    .upd_vpn_i(upd_vpn),
    .lk_idx0_i(l0), .lk_idx1_i(l1), .lk_idx2_i(l2), .lk_idx3_i(l3),
    .hit_o(hit), .hit_512g_o(h512), .hit_1g_o(h1g), .hit_2m_o(h2m)
  );

  function automatic logic [TAG_W-1:0] pk(input logic [IDX_W-1:0] a3, a2, a1, a0);
    return {a3, a2, a1, a0};
  endfunction

  // fields: req | valid | {512g,1g,2m} | write tag | lookup | {hit,512g,1g,2m}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {4'd6,  1'b1, 3'b100, pk(9'h0D, 9'h1FF, 9'h1FF, 9'h1FF), pk(9'h0D, 9'h0C, 9'h0B, 9'h0A), 4'b1100}, // R6 hit
    {4'd6,  1'b1, 3'b100, pk(9'h0D, 9'h1FF, 9'h1FF, 9'h1FF), pk(9'h0E, 9'h0C, 9'h0B, 9'h0A), 4'b0000}, // R6 miss
    {4'd5,  1'b1, 3'b010, pk(9'h0D, 9'h0C, 9'h1FF, 9'h1FF),  pk(9'h0D, 9'h0C, 9'h0B, 9'h0A), 4'b1010}, // R5 hit
    {4'd5,  1'b1, 3'b010, pk(9'h0D, 9'h0C, 9'h1FF, 9'h1FF),  pk(9'h0D, 9'h0D, 9'h0B, 9'h0A), 4'b0000}, // R5 miss
    {4'd4,  1'b1, 3'b001, pk(9'h0D, 9'h0C, 9'h0B, 9'h1FF),   pk(9'h0D, 9'h0C, 9'h0B, 9'h0A), 4'b1001}, // R4 hit
    {4'd4,  1'b1, 3'b001, pk(9'h0D, 9'h0C, 9'h0B, 9'h1FF),   pk(9'h0D, 9'h0C, 9'h0C, 9'h0A), 4'b0000}, // R4 miss
    {4'd3,  1'b1, 3'b000, pk(9'h0D, 9'h0C, 9'h0B, 9'h0A),    pk(9'h0D, 9'h0C, 9'h0B, 9'h0A), 4'b1000}, // R3 hit
    {4'd3,  1'b1, 3'b000, pk(9'h0D, 9'h0C, 9'h0B, 9'h0A),    pk(9'h0D, 9'h0C, 9'h0B, 9'h0B), 4'b0000}, // R3 miss
    {4'd8,  1'b0, 3'b000, pk(9'h0D, 9'h0C, 9'h0B, 9'h0A),    pk(9'h0D, 9'h0C, 9'h0B, 9'h0A), 4'b0000}, // R8
    {4'd10, 1'b1, 3'b110, pk(9'h0D, 9'h1FF, 9'h1FF, 9'h1FF), pk(9'h0D, 9'h0C, 9'h0B, 9'h0A), 4'b1100}, // R10
    {4'd10, 1'b1, 3'b011, pk(9'h0D, 9'h0C, 9'h1FF, 9'h1FF),  pk(9'h0D, 9'h0C, 9'h0B, 9'h0A), 4'b1010}, // R10
    {4'd7,  1'b1, 3'b000, pk(9'h1FF, 9'h0C, 9'h0B, 9'h0A),   pk(9'h0D, 9'h0C, 9'h0B, 9'h0A), 4'b0000}  // R7
  };

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: {hit,512g,1g,2m} actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic write(input logic v, input logic [2:0] f, input logic [TAG_W-1:0] t);
    @(negedge clk);
    upd_en = 1'b1; upd_valid = v; {s512, s1g, s2m} = f; upd_vpn = t;
    @(posedge clk);
    #1 upd_en = 1'b0;
  endtask

  task automatic lookup(input logic [TAG_W-1:0] t);
    @(negedge clk);
    {l3, l2, l1, l0} = t;
    #1;
  endtask

  initial begin
    #1_000_000;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: reset state, all-zero lookup matches the cleared tag but must miss
    lookup('0);
    check("R1", {hit, h512, h1g, h2m}, 4'b0000);

    for (int i = 0; i < NVEC; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      write(v[VW-5], v[VW-6 -: 3], v[4+TAG_W +: TAG_W]);
      lookup(v[4 +: TAG_W]);
      check($sformatf("R%0d vec%0d", v[VW-1 -: 4], i), {hit, h512, h1g, h2m}, v[3:0]);
    end

    // R2: update inputs change without enable, entry keeps hitting
    write(1'b1, 3'b000, pk(9'h0D, 9'h0C, 9'h0B, 9'h0A));
    @(negedge clk);
    upd_valid = 1'b0; {s512, s1g, s2m} = 3'b111; upd_vpn = pk(9'h1, 9'h2, 9'h3, 9'h4);
    repeat (3) @(posedge clk);
    lookup(pk(9'h0D, 9'h0C, 9'h0B, 9'h0A));
    check("R2", {hit, h512, h1g, h2m}, 4'b1000);

    // R11: write and lookup in the same cycle see the old entry
    @(negedge clk);
    upd_en = 1'b1; upd_valid = 1'b1; {s512, s1g, s2m} = 3'b001;
    upd_vpn = pk(9'h1, 9'h2, 9'h3, 9'h4);
    {l3, l2, l1, l0} = pk(9'h0D, 9'h0C, 9'h0B, 9'h0A);
    #1 check("R11 before edge", {hit, h512, h1g, h2m}, 4'b1000);
    @(posedge clk);
    #1 upd_en = 1'b0;
    check("R11 after edge old", {hit, h512, h1g, h2m}, 4'b0000);
    lookup(pk(9'h1, 9'h2, 9'h3, 9'h77));
    check("R11 after edge new", {hit, h512, h1g, h2m}, 4'b1001);

    // R1: reset in mid-run clears the entry
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
    check("R1 after rerun reset", {hit, h512, h1g, h2m}, 4'b0000);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule